// File: doc/BRIEF.md
# Operating-Point Request Controller

This block takes requests from software over a small 32-bit register bus and runs each one as a timed operation against a back-end model. There are three request classes. Class 0 and class 1 are performance-level changes for processor cluster A and cluster B. Class 2 is a read from a system-configuration space. Only one operation runs at a time, and each one takes a fixed number of cycles, `LAT`. A real system would need milliseconds; the default latency is scaled down so that simulation stays short.

When an operation ends, the block sets a completion flag or an error flag for its class in one shared status word. While any flag is set, a level-high interrupt stays asserted. Software reads the status word, and that read clears the flags. A successful configuration read leaves its result in a read-data register.

The back-end model holds an eight-entry frequency table for each cluster, placed in the configuration space.

Top module: `opp_req_ctrl`

## Requirements

The register map uses byte offsets. A word is selected only when `bus_addr[1:0]` is 0.

| Offset | Register | Access |
|---|---|---|
| 0x00 | Cluster A level | read/write |
| 0x04 | Cluster B level | read/write |
| 0x08 | Command | write only, reads as 0 |
| 0x0C | Read data | read only |
| 0x10 | Status | read, clears on read |

- R1: After reset, the following all read 0 and `irq` is low:
  - both level registers
  - the read-data register
  - the status register
- R2: A write of a value 0..7 to a cluster's level register starts an operation.
  - Reading that level register returns the old level until the operation ends.
  - The operation ends `LAT` cycles after the write edge. From then on, the register reads the new value.
- R3: A level write with a value of 8 or more does not start an operation.
  - The error flag for that class is set at the write edge.
  - The level and the completion flag are left unchanged.
- R4: The status word holds a flag pair for each class t:
  - bit 4*t is the completion flag;
  - bit 4*t+1 is the error flag;
  - all other bits read 0.
- R5: Command word fields:
  - bit 31: start;
  - bits 23:20: function code;
  - bits 11:0: word offset;
  - bits 30:24 and 19:12: ignored.

  A command write with bit 31 clear has no effect: no flag, no interrupt, and the read-data register is unchanged.
- R6: A started command with function 6 and an offset inside a table ends after `LAT` cycles with status bit 8 set.
  - Cluster A's table is at offsets 64..71; cluster B's table is at offsets 72..79.
  - For entry i, the read-data value is `300000 + 50000*i` for cluster A and `200000 + 50000*i` for cluster B.
  - The value is truncated to 20 bits. Bits 31:20 are 0.
- R7: A started command with a function code other than 6 sets status bit 9 at the write edge.
  - A command with function 6 and an offset outside both tables sets bit 9 after `LAT` cycles.
  - In both cases the read-data register is unchanged.
- R8: A request that arrives while an operation is in flight is rejected.
  - The rejected request sets its own class's error flag at that edge.
  - The operation in flight still completes normally.
- R9: `irq` is high exactly while any status flag is set.
  - A status read returns the flags and clears them.
  - After a status read in which no new flag is raised, `irq` is low.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_sel` with `bus_wr` low |
| irq | output | 1 | Level-high completion interrupt |

## Verification

Some internal faults show up at the ports as follows:
- A latency counter that is off by one moves the rising edge of `irq` one cycle away from `LAT` after the write edge.
- A wrong class index places a flag at the wrong 4-bit stride of the status word. The same status read reveals this.
- A busy state that is held or dropped wrongly shows up as:
  - a rejected request that sets no error flag, or
  - an in-flight operation that never completes, which leaves `irq` low past the expected cycle.
- Table indexing faults appear in the read-data word of the first configuration read that touches the faulty entry.

// File: rtl/opp_pkg.sv
package opp_pkg;
  localparam int unsigned N_CLS       = 3;
  localparam int unsigned N_CLUS      = 2;
  localparam int unsigned FLAG_STRIDE = 4;
  localparam int unsigned STAT_W      = N_CLS * FLAG_STRIDE;
  localparam int unsigned DATA_W      = 32;

  localparam logic [1:0] CLS_A   = 2'd0;
  localparam logic [1:0] CLS_B   = 2'd1;
  localparam logic [1:0] CLS_CFG = 2'd2;

  // word indices of the register map
  localparam int unsigned REG_LVL_A = 0;
  localparam int unsigned REG_LVL_B = 1;
  localparam int unsigned REG_CMD   = 2;
  localparam int unsigned REG_RDATA = 3;
  localparam int unsigned REG_STAT  = 4;

  // command word fields
  localparam int unsigned START_BIT = 31;
  localparam int unsigned FUNC_LO   = 20;
  localparam int unsigned FUNC_W    = 4;
  localparam int unsigned FUNC_HI   = FUNC_LO + FUNC_W - 1;
  localparam logic [FUNC_W-1:0] CFG_FUNC = 4'd6;
endpackage

// File: rtl/opp_rst_sync.sv
module opp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/opp_decode.sv
module opp_decode
  import opp_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned LVL_N  = 8,
  parameter int unsigned OFS_W  = 12
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rd_en,
  output logic [ADDR_W-3:0] rd_word,
  output logic              rd_stat,
  output logic              req_vld,
  output logic [1:0]        req_cls,
  output logic              req_bad,
  output logic [OFS_W-1:0]  req_arg
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic              hit;
  logic [WORD_W-1:0] word;

  assign hit     = bus_sel && (bus_addr[1:0] == 2'b00);
  assign word    = bus_addr[ADDR_W-1:2];
  assign rd_en   = hit && !bus_wr;
  assign rd_word = word;
  assign rd_stat = rd_en && (word == WORD_W'(REG_STAT));

  always_comb begin
    req_vld = 1'b0;
    req_cls = CLS_A;
    req_bad = 1'b0;
    req_arg = bus_wdata[OFS_W-1:0];
    if (hit && bus_wr) begin
      if (word == WORD_W'(REG_LVL_A) || word == WORD_W'(REG_LVL_B)) begin
        req_vld = 1'b1;
        req_cls = (word == WORD_W'(REG_LVL_A)) ? CLS_A : CLS_B;
        req_bad = (bus_wdata >= DATA_W'(LVL_N));
      end else if (word == WORD_W'(REG_CMD) && bus_wdata[START_BIT]) begin
        req_vld = 1'b1;
        req_cls = CLS_CFG;
        req_bad = (bus_wdata[FUNC_HI:FUNC_LO] != CFG_FUNC);
      end
    end
  end
endmodule

// File: rtl/opp_backend.sv
module opp_backend
  import opp_pkg::*;
#(
  parameter int unsigned OFS_W    = 12,
  parameter int unsigned TBL_N    = 8,
  parameter int unsigned BASE_A   = 64,
  parameter int unsigned BASE_B   = 72,
  parameter int unsigned F_BASE_A = 300000,
  parameter int unsigned F_BASE_B = 200000,
  parameter int unsigned F_STEP   = 50000,
  parameter int unsigned FREQ_W   = 20
) (
  input  logic [OFS_W-1:0]  ofs,
  output logic              hit,
  output logic [DATA_W-1:0] data
);
  logic [N_CLUS-1:0] c_hit;
  logic [FREQ_W-1:0] c_val [N_CLUS];

  for (genvar c = 0; c < N_CLUS; c++) begin : g_tbl
    localparam int unsigned TB = (c == 0) ? BASE_A : BASE_B;
    localparam int unsigned FB = (c == 0) ? F_BASE_A : F_BASE_B;
    logic [31:0] rel;
    assign rel      = 32'(ofs) - TB;
    assign c_hit[c] = (rel < TBL_N);
    assign c_val[c] = FREQ_W'(FB) + FREQ_W'(F_STEP) * rel[FREQ_W-1:0];
  end

  assign hit  = |c_hit;
  assign data = c_hit[0] ? DATA_W'(c_val[0]) : DATA_W'(c_val[1]);
endmodule

// File: rtl/opp_seq.sv
module opp_seq
  import opp_pkg::*;
#(
  parameter int unsigned LAT   = 20,
  parameter int unsigned LVL_W = 3,
  parameter int unsigned OFS_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [1:0]        req_cls,
  input  logic              req_bad,
  input  logic [OFS_W-1:0]  req_arg,
  input  logic              rd_stat,
  input  logic              be_hit,
  input  logic [DATA_W-1:0] be_data,
  output logic              busy,
  output logic              fin,
  output logic [OFS_W-1:0]  be_ofs,
  output logic [STAT_W-1:0] status,
  output logic [LVL_W-1:0]  lvl_a,
  output logic [LVL_W-1:0]  lvl_b,
  output logic [DATA_W-1:0] rd_val
);
  localparam int unsigned CNT_W = $clog2(LAT + 1);

  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [1:0]        cls_q;
  logic [OFS_W-1:0]  arg_q;
  logic [STAT_W-1:0] status_q, status_d, set;
  logic [DATA_W-1:0] rdata_q;
  logic [LVL_W-1:0]  lvl_q [N_CLUS];
  logic [N_CLUS-1:0] lvl_en;
  logic              acc_en, rd_upd;

  always_comb begin
    fin    = busy_q && (cnt_q == '0);
    set    = '0;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    acc_en = 1'b0;
    rd_upd = 1'b0;
    lvl_en = '0;
    if (busy_q && !fin) cnt_d = cnt_q - 1'b1;
    if (fin) begin
      busy_d = 1'b0;
      if (cls_q == CLS_CFG) begin
        if (be_hit) begin
          rd_upd = 1'b1;
          set[FLAG_STRIDE*2] = 1'b1;
        end else begin
          set[FLAG_STRIDE*2+1] = 1'b1;
        end
      end else begin
        for (int c = 0; c < N_CLUS; c++) begin
          if (cls_q == 2'(c)) begin
            lvl_en[c] = 1'b1;
            set[FLAG_STRIDE*c] = 1'b1;
          end
        end
      end
    end
    if (req_vld) begin
      if (req_bad || (busy_q && !fin)) begin
        for (int t = 0; t < N_CLS; t++)
          if (req_cls == 2'(t)) set[FLAG_STRIDE*t+1] = 1'b1;
      end else begin
        busy_d = 1'b1;
        cnt_d  = CNT_W'(LAT - 1);
        acc_en = 1'b1;
      end
    end
    status_d = (rd_stat ? '0 : status_q) | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      cls_q    <= CLS_A;
      arg_q    <= '0;
      status_q <= '0;
      rdata_q  <= '0;
    end else begin
      busy_q   <= busy_d;
      cnt_q    <= cnt_d;
      status_q <= status_d;
      if (acc_en) begin
        cls_q <= req_cls;
        arg_q <= req_arg;
      end
      if (rd_upd) rdata_q <= be_data;
    end
  end

  for (genvar c = 0; c < N_CLUS; c++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         lvl_q[c] <= '0;
      else if (lvl_en[c]) lvl_q[c] <= arg_q[LVL_W-1:0];
    end
  end

  assign busy   = busy_q;
  assign be_ofs = arg_q;
  assign status = status_q;
  assign lvl_a  = lvl_q[0];
  assign lvl_b  = lvl_q[1];
  assign rd_val = rdata_q;
endmodule

// File: rtl/opp_req_ctrl.sv
module opp_req_ctrl
  import opp_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned LAT      = 20,
  parameter int unsigned LVL_N    = 8,
  parameter int unsigned OFS_W    = 12,
  parameter int unsigned TBL_N    = 8,
  parameter int unsigned BASE_A   = 64,
  parameter int unsigned BASE_B   = 72,
  parameter int unsigned F_BASE_A = 300000,
  parameter int unsigned F_BASE_B = 200000,
  parameter int unsigned F_STEP   = 50000,
  parameter int unsigned FREQ_W   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int unsigned LVL_W  = $clog2(LVL_N);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic              rst_sn;
  logic              rd_en, rd_stat;
  logic [WORD_W-1:0] rd_word;
  logic              req_vld, req_bad;
  logic [1:0]        req_cls;
  logic [OFS_W-1:0]  req_arg, be_ofs;
  logic              be_hit, busy, fin;
  logic [DATA_W-1:0] be_data, rd_val;
  logic [STAT_W-1:0] status;
  logic [LVL_W-1:0]  lvl_a, lvl_b;

  opp_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  opp_decode #(.ADDR_W(ADDR_W), .LVL_N(LVL_N), .OFS_W(OFS_W)) u_dec (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_en(rd_en), .rd_word(rd_word), .rd_stat(rd_stat),
    .req_vld(req_vld), .req_cls(req_cls), .req_bad(req_bad), .req_arg(req_arg)
  );

  opp_seq #(.LAT(LAT), .LVL_W(LVL_W), .OFS_W(OFS_W)) u_seq (
    .clk(clk), .rst_n(rst_sn),
    .req_vld(req_vld), .req_cls(req_cls), .req_bad(req_bad), .req_arg(req_arg),
    .rd_stat(rd_stat), .be_hit(be_hit), .be_data(be_data),
    .busy(busy), .fin(fin), .be_ofs(be_ofs), .status(status),
    .lvl_a(lvl_a), .lvl_b(lvl_b), .rd_val(rd_val)
  );

  opp_backend #(
    .OFS_W(OFS_W), .TBL_N(TBL_N), .BASE_A(BASE_A), .BASE_B(BASE_B),
    .F_BASE_A(F_BASE_A), .F_BASE_B(F_BASE_B), .F_STEP(F_STEP), .FREQ_W(FREQ_W)
  ) u_be (.ofs(be_ofs), .hit(be_hit), .data(be_data));

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      if      (rd_word == WORD_W'(REG_LVL_A)) bus_rdata = 32'(lvl_a);
      else if (rd_word == WORD_W'(REG_LVL_B)) bus_rdata = 32'(lvl_b);
      else if (rd_word == WORD_W'(REG_RDATA)) bus_rdata = rd_val;
      else if (rd_word == WORD_W'(REG_STAT))  bus_rdata = 32'(status);
    end
  end

  assign irq = |status;
endmodule

// File: rtl/opp_chk.sv
module opp_chk #(
  parameter int unsigned LVL_W  = 3,
  parameter int unsigned STAT_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              fin,
  input logic              req_vld,
  input logic              req_bad,
  input logic [1:0]        req_cls,
  input logic              rd_stat,
  input logic [STAT_W-1:0] status,
  input logic              irq,
  input logic [LVL_W-1:0]  lvl_a,
  input logic [LVL_W-1:0]  lvl_b
);
  function automatic logic [STAT_W-1:0] used_mask();
    logic [STAT_W-1:0] m;
    m = '0;
    for (int b = 0; b < STAT_W; b++) if ((b % 4) < 2) m[b] = 1'b1;
    return m;
  endfunction
  localparam logic [STAT_W-1:0] USED = used_mask();

  // R2: a level changes only on the edge that finishes an operation
  a_r2_level_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(lvl_a) || !$stable(lvl_b)) |-> $past(fin));

  // R3: an out-of-range level write leaves the level and raises the error flag
  a_r3_bad_level_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_bad && req_cls == 2'd0 && !fin) |=> ($stable(lvl_a) && status[1]));

  // R4: only the flag-pair bits of the status word may be set
  a_r4_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~USED) == '0);

  // R8: a request during an operation is rejected with its class error flag
  a_r8_busy_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin && req_vld && req_cls == 2'd1) |=> status[5]);

  // R9: a status read with nothing new raised drops the interrupt
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !req_vld && !fin) |=> !irq);
endmodule

bind opp_req_ctrl opp_chk #(.LVL_W(LVL_W), .STAT_W(opp_pkg::STAT_W)) u_chk (
  .clk(clk), .rst_n(rst_sn), .busy(busy), .fin(fin), .req_vld(req_vld),
  .req_bad(req_bad), .req_cls(req_cls), .rd_stat(rd_stat), .status(status),
  .irq(irq), .lvl_a(lvl_a), .lvl_b(lvl_b)
);

// File: tb/tb_opp_req_ctrl.sv
module tb_opp_req_ctrl;
  localparam int LAT = 20;
  localparam logic [4:0] A_LA = 5'h00, A_LB = 5'h04, A_CMD = 5'h08, A_RD = 5'h0C, A_ST = 5'h10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, sel, wr;
  logic [4:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;
  int n_run = 0, n_fail = 0;

  opp_req_ctrl dut (.clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
                    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq));

  function automatic logic [31:0] exp_freq(int c, int i);
    logic [31:0] f;
    f = ((c == 0) ? 32'd300000 : 32'd200000) + 32'd50000 * i;
    return f & 32'h000F_FFFF;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bw(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(posedge clk); #1; sel = 0; wr = 0;
  endtask

  task automatic br(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1; wr = 0; addr = a; #1 d = rdata;
    @(posedge clk); #1; sel = 0;
  endtask

  task automatic wait_irq();
    for (int k = 0; k < LAT + 6 && !irq; k++) @(negedge clk);
  endtask

  logic [31:0] v;
  int lv [2];

  initial begin
    sel = 0; wr = 0; addr = '0; wdata = '0; rst_n = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    repeat (4) @(posedge clk);

    // R1 reset state
    br(A_LA, v); chk("R1 level A", v, 0);
    br(A_LB, v); chk("R1 level B", v, 0);
    br(A_RD, v); chk("R1 read data", v, 0);
    br(A_ST, v); chk("R1 status", v, 0);
    chk("R1 irq", 32'(irq), 0);
    lv[0] = 0; lv[1] = 0;

    // R2 / R4 / R9: every level on both clusters
    for (int c = 0; c < 2; c++) begin
      for (int k = 0; k < 8; k++) begin
        int l;
        l = (k * 3 + 1) % 8;
        bw(c ? A_LB : A_LA, 32'(l));
        br(c ? A_LB : A_LA, v); chk("R2 old level during op", v, 32'(lv[c]));
        repeat (LAT - 2) @(posedge clk);
        @(negedge clk); chk("R9 irq low before finish", 32'(irq), 0);
        @(posedge clk);
        @(negedge clk); chk("R9 irq at finish", 32'(irq), 1);
        br(A_ST, v); chk("R4 complete flag position", v, 32'(1) << (4 * c));
        br(A_ST, v); chk("R9 status cleared by read", v, 0);
        chk("R9 irq low after read", 32'(irq), 0);
        br(c ? A_LB : A_LA, v); chk("R2 new level", v, 32'(l));
        lv[c] = l;
      end
    end

    // R3 out-of-range levels
    for (int c = 0; c < 2; c++) begin
      for (int k = 0; k < 4; k++) begin
        logic [31:0] bad;
        bad = (k == 0) ? 32'd8 : (k == 1) ? 32'd9 : (k == 2) ? 32'd15 : 32'h8000_0003;
        bw(c ? A_LB : A_LA, bad);
        @(negedge clk); chk("R3 irq at write edge", 32'(irq), 1);
        br(A_ST, v); chk("R3 error flag only", v, 32'(2) << (4 * c));
        br(c ? A_LB : A_LA, v); chk("R3 level unchanged", v, 32'(lv[c]));
      end
    end

    // R5 command without start flag
    bw(A_CMD, (32'd6 << 20) | 32'd64);
    repeat (LAT + 3) @(posedge clk);
    @(negedge clk); chk("R5 no irq without start", 32'(irq), 0);
    br(A_ST, v); chk("R5 no status without start", v, 0);
    br(A_RD, v); chk("R5 read data unchanged", v, 0);

    // R6 every table entry
    for (int c = 0; c < 2; c++) begin
      for (int i = 0; i < 8; i++) begin
        bw(A_CMD, 32'h8000_0000 | 32'h7F00_0000 | (32'd6 << 20) | (32'hA5 << 12) | 32'(64 + 8 * c + i));
        repeat (LAT - 1) @(posedge clk);
        @(negedge clk); chk("R6 irq low before finish", 32'(irq), 0);
        @(posedge clk);
        @(negedge clk); chk("R6 irq at finish", 32'(irq), 1);
        br(A_ST, v); chk("R6 status bit 8", v, 32'h100);
        br(A_RD, v); chk("R6 table value", v, exp_freq(c, i));
      end
    end

    // R7 wrong function and unmapped offset
    bw(A_CMD, 32'h8000_0000 | (32'd5 << 20) | 32'd64);
    @(negedge clk); chk("R7 irq for bad function", 32'(irq), 1);
    br(A_ST, v); chk("R7 bad function error", v, 32'h200);
    bw(A_CMD, 32'h8000_0000 | (32'd6 << 20) | 32'd80);
    repeat (LAT - 1) @(posedge clk);
    @(negedge clk); chk("R7 irq low before finish", 32'(irq), 0);
    @(posedge clk);
    @(negedge clk); chk("R7 irq at finish", 32'(irq), 1);
    br(A_ST, v); chk("R7 unmapped offset error", v, 32'h200);
    br(A_RD, v); chk("R7 read data unchanged", v, exp_freq(1, 7));

    // R8 rejection while busy
    bw(A_LA, 32'd3);
    repeat (4) @(posedge clk);
    bw(A_LB, 32'd2);
    @(negedge clk); chk("R8 irq on reject", 32'(irq), 1);
    br(A_ST, v); chk("R8 cluster B error", v, 32'h20);
    bw(A_CMD, 32'h8000_0000 | (32'd6 << 20) | 32'd65);
    br(A_ST, v); chk("R8 config error", v, 32'h200);
    wait_irq();
    chk("R8 in-flight completes", 32'(irq), 1);
    br(A_ST, v); chk("R8 cluster A complete", v, 32'h1);
    br(A_LA, v); chk("R8 level A updated", v, 3);
    br(A_LB, v); chk("R8 level B unchanged", v, 32'(lv[1]));
    br(A_RD, v); chk("R8 read data unchanged", v, exp_freq(1, 7));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule